// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a 256-word by 16-bit serial EEPROM on a three-wire bus with a chip select, a serial clock and separate data-in and data-out lines. The serial clock and the select are sampled in the system clock domain. A frame is shifted in on rising serial-clock edges. It begins with a start bit of 1, followed by a 2-bit opcode and an 8-bit address sent most significant bit first. Reads return a word on the data-out line. Write, erase and the two whole-array commands run a self-timed programming cycle, whose length is a parameter counted in system clock cycles.

All programming is gated by a write-enable latch. The latch is clear after reset. While a programming cycle runs, data-out reports ready/busy status whenever the select is high. The storage is a plain register array that an FPGA tool can map to block RAM.

Top module: `microwire_eeprom`

## Requirements
- R1: After reset, `dout_en` is low and programming is disabled: a WRITE sent before any enable command starts no cycle, so raising `cs` afterwards leaves `dout_en` low.
- R2: A frame is a start bit 1, opcode bits OP1 OP0, then address A7..A0. Opcode 10 is READ. After the last address bit, `dout` drives a dummy 0. The next 16 rising `sk` edges then present D15..D0, MSB first.
- R3: Opcode 00 with A7:A6 = 11 sets the write-enable latch, and with A7:A6 = 00 clears it. A WRITE sent while the latch is clear leaves the word unchanged.
- R4: The state of the write-enable latch has no effect on READ.
- R5: Opcode 01 is WRITE, followed by data bits. If more than 16 data bits arrive before `cs` falls, the last 16 are stored.
- R6: Programming starts only on the `cs` falling edge after a complete frame. A frame cut short, for example a WRITE with fewer than 16 data bits, is discarded.
- R7: Once a cycle has started, raising `cs` makes `dout_en` high. `dout` then reads 0 while the cycle runs and 1 once it has finished.
- R8: A rising `sk` edge with `cs` high and `di` high clears the ready/busy indication, and `dout_en` falls.
- R9: Opcode 11 is ERASE, which sets the addressed word to 16'hFFFF.
- R10: Opcode 00 with A7:A6 = 10 (whole-array erase) sets every word to 16'hFFFF. Opcode 00 with A7:A6 = 01 (whole-array write) is followed by 16 data bits and stores that pattern in every word.
- R11: While a programming cycle runs, new frames are ignored. A READ then leaves `dout_en` low, and a WRITE changes nothing.
- R12: When neither status nor read data is being driven, `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, sampled by `clk` |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out / ready-busy flag |
| dout_en | output | 1 | Output enable for `dout` |

## Verification
A wrong frame counter or a wrong decode shows at the ports within one frame. The read that follows returns the wrong word, or the dummy bit is missing and the word appears shifted by one position. A wrong write-enable latch or programming timer shows as `dout_en` staying low after `cs` is raised, or as a busy flag that never turns ready. A stuck busy state shows when a later frame is ignored and the read-back returns the old word. Every read-back happens right after the programming cycle completes, so a fault appears no later than the next instruction.

// File: rtl/uwe_pkg.sv
package uwe_pkg;

  typedef enum logic [2:0] {
    OP_NONE, OP_READ, OP_WRITE, OP_ERASE, OP_WEN, OP_WDS, OP_WRALL, OP_ERAL
  } uwe_op_e;

  // opcode plus the two top address bits select the command
  function automatic uwe_op_e uwe_decode(input logic [1:0] opc, input logic [1:0] sub);
    uwe_op_e r;
    case (opc)
      2'b10:   r = OP_READ;
      2'b01:   r = OP_WRITE;
      2'b11:   r = OP_ERASE;
      default: begin
        case (sub)
          2'b11:   r = OP_WEN;
          2'b00:   r = OP_WDS;
          2'b01:   r = OP_WRALL;
          default: r = OP_ERAL;
        endcase
      end
    endcase
    return r;
  endfunction

  function automatic logic uwe_has_data(input uwe_op_e op);
    return (op == OP_WRITE) || (op == OP_WRALL);
  endfunction

  function automatic logic uwe_is_prog(input uwe_op_e op);
    return (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_WRALL) || (op == OP_ERAL);
  endfunction

  function automatic logic uwe_is_bulk(input uwe_op_e op);
    return (op == OP_WRALL) || (op == OP_ERAL);
  endfunction

endpackage

// File: rtl/uwe_pin_sync.sv
module uwe_pin_sync (
  input  logic clk,
  input  logic rst,
  input  logic sk_i,
  input  logic cs_i,
  input  logic di_i,
  output logic sk_rise,
  output logic cs_fall,
  output logic cs_lvl,
  output logic di_lvl
);
  logic sk_q, sk_qq, cs_q, cs_qq, di_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sk_q  <= 1'b0;
      sk_qq <= 1'b0;
      cs_q  <= 1'b0;
      cs_qq <= 1'b0;
      di_q  <= 1'b0;
    end else begin
      sk_q  <= sk_i;
      sk_qq <= sk_q;
      cs_q  <= cs_i;
      cs_qq <= cs_q;
      di_q  <= di_i;
    end
  end

  assign sk_rise = sk_q & ~sk_qq;
  assign cs_fall = ~cs_q & cs_qq;
  assign cs_lvl  = cs_q;
  assign di_lvl  = di_q;
endmodule

// File: rtl/uwe_frame.sv
module uwe_frame
  import uwe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sk_rise,
  input  logic              cs_fall,
  input  logic              cs_lvl,
  input  logic              di_lvl,
  input  logic              busy,
  input  logic [DATA_W-1:0] rdata,
  output logic              req,
  output uwe_op_e           req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_active,
  output logic              rd_bit
);
  localparam int HDR_W  = 2 + ADDR_W;
  localparam int CNT_W  = $clog2(HDR_W + 1);
  localparam int DCNT_W = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {FS_IDLE, FS_HDR, FS_DATA, FS_RD, FS_DONE} fs_e;

  fs_e               st;
  logic [HDR_W-1:0]  hdr_q;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] data_q;
  logic [DCNT_W-1:0] dcnt;
  logic [DATA_W-1:0] rd_sh;
  logic              rd_first;
  uwe_op_e           op_q;

  logic [HDR_W-1:0]  hdr_nx;
  uwe_op_e           op_nx;
  logic [DATA_W-1:0] rd_src;

  assign hdr_nx = {hdr_q[HDR_W-2:0], di_lvl};
  assign op_nx  = uwe_decode(hdr_nx[HDR_W-1 -: 2], hdr_nx[ADDR_W-1 -: 2]);
  assign rd_src = rd_first ? rdata : rd_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FS_IDLE;
      hdr_q    <= '0;
      cnt      <= '0;
      data_q   <= '0;
      dcnt     <= '0;
      rd_sh    <= '0;
      rd_first <= 1'b0;
      rd_bit   <= 1'b0;
      op_q     <= OP_NONE;
      req      <= 1'b0;
    end else begin
      req <= 1'b0;
      if (!cs_lvl) begin
        if (cs_fall && ((st == FS_DATA && dcnt == DCNT_W'(DATA_W)) || st == FS_DONE))
          req <= 1'b1;
        st <= FS_IDLE;
      end else if (sk_rise) begin
        case (st)
          FS_IDLE: begin
            if (di_lvl && !busy && !req) begin
              st  <= FS_HDR;
              cnt <= '0;
            end
          end
          FS_HDR: begin
            hdr_q <= hdr_nx;
            cnt   <= cnt + 1'b1;
            if (cnt == CNT_W'(HDR_W - 1)) begin
              op_q <= op_nx;
              if (op_nx == OP_READ) begin
                st       <= FS_RD;
                rd_first <= 1'b1;
                rd_bit   <= 1'b0;
              end else if (uwe_has_data(op_nx)) begin
                st   <= FS_DATA;
                dcnt <= '0;
              end else begin
                st <= FS_DONE;
              end
            end
          end
          FS_DATA: begin
            data_q <= {data_q[DATA_W-2:0], di_lvl};
            if (dcnt != DCNT_W'(DATA_W)) dcnt <= dcnt + 1'b1;
          end
          FS_RD: begin
            rd_bit   <= rd_src[DATA_W-1];
            rd_sh    <= {rd_src[DATA_W-2:0], 1'b0};
            rd_first <= 1'b0;
          end
          default: ;
        endcase
      end else if (st == FS_RD && rd_first) begin
        rd_sh <= rdata;
      end
    end
  end

  assign req_op    = op_q;
  assign req_addr  = hdr_q[ADDR_W-1:0];
  assign req_data  = data_q;
  assign rd_addr   = hdr_q[ADDR_W-1:0];
  assign rd_active = (st == FS_RD);

  // R11: a running programming cycle keeps the frame receiver parked
  a_r11_idle_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> (st == FS_IDLE));
endmodule

// File: rtl/uwe_prog.sv
module uwe_prog
  import uwe_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  uwe_op_e           req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              started,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int PROG_LEN = (PROG_CYCLES > DEPTH) ? PROG_CYCLES : DEPTH;
  localparam int TW       = $clog2(PROG_LEN + 1);

  logic              wen;
  logic [TW-1:0]     tmr;
  uwe_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      started <= 1'b0;
      wen     <= 1'b0;
      tmr     <= '0;
      op_q    <= OP_NONE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      started <= 1'b0;
      if (busy) begin
        if (tmr == TW'(PROG_LEN - 1)) busy <= 1'b0;
        tmr <= tmr + 1'b1;
      end else if (req) begin
        if (req_op == OP_WEN) begin
          wen <= 1'b1;
        end else if (req_op == OP_WDS) begin
          wen <= 1'b0;
        end else if (wen && uwe_is_prog(req_op)) begin
          busy    <= 1'b1;
          started <= 1'b1;
          tmr     <= '0;
          op_q    <= req_op;
          addr_q  <= req_addr;
          data_q  <= uwe_has_data(req_op) ? req_data : '1;
        end
      end
    end
  end

  // single-word commands write once; whole-array commands sweep one word per clock
  assign we    = busy && (uwe_is_bulk(op_q) ? (tmr < TW'(DEPTH)) : (tmr == '0));
  assign waddr = uwe_is_bulk(op_q) ? tmr[ADDR_W-1:0] : addr_q;
  assign wdata = data_q;

  // R7: busy ends only after the full programming time
  a_r7_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(tmr) == TW'(PROG_LEN - 1)));

  // R3: the enable latch cannot move while a cycle is running
  a_r3_wen_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(wen));
endmodule

// File: rtl/uwe_mem.sv
module uwe_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/microwire_eeprom.sv
module microwire_eeprom
  import uwe_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout,
  output logic dout_en
);
  logic              sk_rise, cs_fall, cs_lvl, di_lvl;
  logic              busy, started, req, rd_active, rd_bit, we;
  uwe_op_e           req_op;
  logic [ADDR_W-1:0] req_addr, rd_addr, waddr;
  logic [DATA_W-1:0] req_data, rdata, wdata;
  logic              status_on;

  uwe_pin_sync u_sync (
    .clk(clk), .rst(rst), .sk_i(sk), .cs_i(cs), .di_i(di),
    .sk_rise(sk_rise), .cs_fall(cs_fall), .cs_lvl(cs_lvl), .di_lvl(di_lvl)
  );

  uwe_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .sk_rise(sk_rise), .cs_fall(cs_fall), .cs_lvl(cs_lvl),
    .di_lvl(di_lvl), .busy(busy), .rdata(rdata), .req(req), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .rd_addr(rd_addr),
    .rd_active(rd_active), .rd_bit(rd_bit)
  );

  uwe_prog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst(rst), .req(req), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .busy(busy), .started(started), .we(we),
    .waddr(waddr), .wdata(wdata)
  );

  uwe_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata), .raddr(rd_addr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_on <= 1'b0;
      dout      <= 1'b1;
      dout_en   <= 1'b0;
    end else begin
      if (started) status_on <= 1'b1;
      else if (cs_lvl && sk_rise && di_lvl) status_on <= 1'b0;
      dout_en <= cs_lvl && (status_on || rd_active);
      dout    <= status_on ? ~busy : (rd_active ? rd_bit : 1'b1);
    end
  end

  // R12: nothing is driven once the select has been low
  a_r12_quiet_deselected: assert property (@(posedge clk) disable iff (rst)
    $past(!cs_lvl) |-> !dout_en);

  // R2: read data and status never share the output
  a_r2_read_excludes_status: assert property (@(posedge clk) disable iff (rst)
    rd_active |-> !status_on);
endmodule

// File: tb/microwire_eeprom_test.sv
module microwire_eeprom_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs  = 1'b0;
  logic sk  = 1'b0;
  logic di  = 1'b0;
  logic dout, dout_en;
  int   n_run  = 0;
  int   n_fail = 0;
  int   cyc    = 0;

  always #(CLK_P/2) clk = ~clk;

  microwire_eeprom #(.PROG_CYCLES(600)) uut (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di), .dout(dout), .dout_en(dout_en)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run = n_run + 1;
    if (got !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    di = b;
    idle(4);
    sk = 1'b1;
    idle(4);
    sk = 1'b0;
  endtask

  task automatic hdr(input logic [1:0] op, input logic [7:0] addr);
    cs = 1'b1;
    idle(2);
    bit_out(1'b1);
    bit_out(op[1]);
    bit_out(op[0]);
    for (int i = 7; i >= 0; i--) bit_out(addr[i]);
  endtask

  task automatic end_frame;
    di = 1'b0;
    idle(2);
    cs = 1'b0;
    idle(6);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [7:0] addr);
    hdr(op, addr);
    end_frame();
  endtask

  task automatic send_data(input logic [1:0] op, input logic [7:0] addr,
                           input logic [31:0] data, input int nbits);
    hdr(op, addr);
    for (int i = nbits - 1; i >= 0; i--) bit_out(data[i]);
    end_frame();
  endtask

  task automatic read_check(input string tag, input logic [7:0] addr, input logic [15:0] exp);
    logic [15:0] w;
    w = '0;
    hdr(2'b10, addr);
    check({tag, " dummy bit"}, {30'd0, dout_en, dout}, 32'h2);
    for (int i = 0; i < 16; i++) begin
      bit_out(1'b0);
      w = {w[14:0], dout};
    end
    end_frame();
    check(tag, {16'd0, w}, {16'd0, exp});
  endtask

  task automatic ready_wait(input string tag);
    int n;
    cs = 1'b1;
    idle(4);
    check({tag, " status driven"}, {31'd0, dout_en}, 32'd1);
    check({tag, " busy first"}, {31'd0, dout}, 32'd0);
    n = 0;
    while (dout !== 1'b1 && n < 900) begin
      idle(1);
      n++;
    end
    check({tag, " ready later"}, {31'd0, dout}, 32'd1);
    bit_out(1'b1);
    check("R8 status cleared by sk with di high", {31'd0, dout_en}, 32'd0);
    end_frame();
  endtask

  task automatic no_cycle(input string tag);
    cs = 1'b1;
    idle(4);
    check(tag, {31'd0, dout_en}, 32'd0);
    cs = 1'b0;
    idle(4);
  endtask

  task automatic t_reset_and_locked;
    check("R1 R12 dout_en low after reset", {31'd0, dout_en}, 32'd0);
    send_data(2'b01, 8'd5, 32'h1234, 16);
    no_cycle("R1 write before enable starts nothing");
  endtask

  task automatic t_erase_all;
    cmd(2'b00, 8'hC0);
    send_data(2'b00, 8'h80, 32'h0, 0);
    ready_wait("R7 R10 erase all");
    read_check("R10 erase all word 5", 8'd5, 16'hFFFF);
    read_check("R10 erase all word 255", 8'd255, 16'hFFFF);
  endtask

  task automatic t_write_read;
    send_data(2'b01, 8'd5, 32'hA55A, 16);
    ready_wait("R7 write");
    read_check("R2 R3 write then read", 8'd5, 16'hA55A);
  endtask

  task automatic t_long_data;
    send_data(2'b01, 8'd6, 32'h000F0F0C, 20);
    ready_wait("R5 long write");
    read_check("R5 last 16 bits kept", 8'd6, 16'h0F0C);
  endtask

  task automatic t_erase;
    send_data(2'b11, 8'd5, 32'h0, 0);
    ready_wait("R9 erase");
    read_check("R9 erase word", 8'd5, 16'hFFFF);
  endtask

  task automatic t_short_frame;
    send_data(2'b01, 8'd7, 32'h3FF, 10);
    no_cycle("R6 short frame starts nothing");
    read_check("R6 short frame discarded", 8'd7, 16'hFFFF);
  endtask

  task automatic t_disabled;
    cmd(2'b00, 8'h00);
    send_data(2'b01, 8'd8, 32'h3C3C, 16);
    no_cycle("R3 write while disabled starts nothing");
    read_check("R3 word unchanged while disabled", 8'd8, 16'hFFFF);
    read_check("R4 read unaffected by disable", 8'd6, 16'h0F0C);
  endtask

  task automatic t_write_all;
    cmd(2'b00, 8'hC0);
    read_check("R4 read unaffected by enable", 8'd6, 16'h0F0C);
    send_data(2'b00, 8'h40, 32'h1357, 16);
    ready_wait("R10 write all");
    read_check("R10 write all word 0", 8'd0, 16'h1357);
    read_check("R10 write all word 128", 8'd128, 16'h1357);
    read_check("R10 write all word 255", 8'd255, 16'h1357);
  endtask

  task automatic t_busy_ignore;
    send_data(2'b01, 8'd9, 32'h0000, 16);
    hdr(2'b10, 8'd9);
    check("R11 R12 read ignored while busy", {31'd0, dout_en}, 32'd0);
    end_frame();
    send_data(2'b01, 8'd10, 32'hBEEF, 16);
    idle(700);
    read_check("R11 write while busy ignored", 8'd10, 16'h1357);
    read_check("R11 first write landed", 8'd9, 16'h0000);
  endtask

  initial begin
    rst = 1'b1;
    idle(5);
    rst = 1'b0;
    idle(2);
    t_reset_and_locked();
    t_erase_all();
    t_write_read();
    t_long_data();
    t_erase();
    t_short_frame();
    t_disabled();
    t_write_all();
    t_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule